// File: doc/BRIEF.md
# Rx Interrupt Coalescing Controller

This block decides when a receive engine should interrupt its host. Instead of raising an interrupt per received message, it accumulates message arrivals into a batch. It fires once the batch reaches a programmable message count, or once a programmable number of timebase ticks has elapsed while at least one message waits. A transmit-side link event also fires the interrupt, even with no messages pending.

When it fires, the block freezes a 32-bit status word. The word carries a 4-bit rolling tag, the batch message count and the link flag. The interrupt line then stays high until the host writes an acknowledge holding the next tag value, which is the previous tag plus one, modulo 16. That write re-arms the engine and supplies the tag for the next batch. Control is done through a small write port. Set and clear addresses change individual control bits, a configuration address loads both limits, and an acknowledge address carries the tag.

A typical host sequence runs in this order. Hold the engine in reset and load the limits. Release reset. Write an initial acknowledge to arm the engine. Finally, set the interrupt enable.

Top module: `rx_irq_coalescer`

## Requirements
- R1: After `rst_n` is released, `irq` is 0, `status` is 0 and `mem_uncached` is 0. The engine reset bit is 1, the interrupt enable is 0, the count limit is 16 and the time limit is 10 ticks.
- R2: A write with `wr_sel`=0 (set) sets each control bit whose `wr_data` bit is 1, and `wr_sel`=1 (clear) clears it. The control bits are: bit 16 memory-uncached flag (driven on `mem_uncached`), bit 17 engine reset, bit 18 interrupt enable. Each takes effect on the clock edge of the write.
- R3: While the engine reset bit is 1, the block behaves as follows. Message and link events are discarded. `status` reads 0 and `irq` is 0. Acknowledge writes are ignored, and the engine stays disarmed until an acknowledge arrives after reset is cleared.
- R4: While armed and enabled, the block fires when the pending message count is nonzero and at least the count limit. The resulting `status` holds the tag in bits 3:0, the count in bits 10:4 and the link flag in bit 16, and it stays unchanged until the next batch fires.
- R5: While armed with at least one message pending, each `tick` advances a batch timer that starts from 0 at every acknowledge and every fire. The block fires one cycle after the timer reaches the time limit.
- R6: A pending link event fires the interrupt one cycle after it is taken, with bit 16 set, even when the message count is 0.
- R7: An acknowledge write (`wr_sel`=3) is taken only while the engine is disarmed or has fired. It loads `wr_data[3:0]` as the tag for the next status word, re-arms the engine and drops `irq` in the following cycle. An acknowledge while already armed is ignored.
- R8: With the interrupt enable at 0, no batch fires and `irq` stays 0. Events keep accumulating, and a due batch fires once the enable is set.
- R9: Events arriving between a fire and its acknowledge, including those in the fire cycle, are counted into the next batch. The pending count saturates at 127.
- R10: A configuration write (`wr_sel`=2) loads the count limit from `wr_data[7:0]` and the time limit from `wr_data[15:8]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| msg_evt | input | 1 | One-cycle pulse per received message |
| link_evt | input | 1 | One-cycle pulse per transmit link event |
| tick | input | 1 | Prescaled timebase pulse, one per time unit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 set, 1 clear, 2 configuration, 3 acknowledge |
| wr_data | input | 32 | Write data |
| irq | output | 1 | Level interrupt request |
| status | output | 32 | Frozen status word of the last fired batch |
| mem_uncached | output | 1 | Memory-uncached control flag |

## Verification
A wrong pending count or timer shows up as an interrupt one or more cycles early or late, or as a wrong count field in the status word. Either is visible at the first fire after the fault. A wrong handshake state shows as `irq` failing to drop in the cycle after an acknowledge, as an interrupt that never comes because an acknowledge was not taken, or as a stale tag in bits 3:0 of the next status word. The bench steps a cycle-level reference model beside the design and compares `irq`, `status` and `mem_uncached` after every edge, so a divergence is reported in the cycle it appears.

// File: rtl/rxc_pkg.sv
package rxc_pkg;

   typedef enum logic [1:0] {
      WSEL_SET = 2'd0,
      WSEL_CLR = 2'd1,
      WSEL_CFG = 2'd2,
      WSEL_ACK = 2'd3
   } wsel_e;

   typedef enum logic [1:0] {
      ENG_IDLE  = 2'd0,
      ENG_ARMED = 2'd1,
      ENG_FIRED = 2'd2
   } eng_state_e;

   // control bit positions (host software decodes these)
   localparam int CTL_UNC_BIT = 16;
   localparam int CTL_RST_BIT = 17;
   localparam int CTL_IEN_BIT = 18;

   // configuration word fields
   localparam int CFG_CNT_LSB  = 0;
   localparam int CFG_TIME_LSB = 8;

   // status word fields
   localparam int ST_TAG_LSB = 0;
   localparam int ST_CNT_LSB = 4;
   localparam int ST_LNK_BIT = 16;
   localparam int STATUS_W   = 32;

endpackage

// File: rtl/rxc_ctrl_regs.sv
module rxc_ctrl_regs
   import rxc_pkg::*;
#(
   parameter int LIM_W        = 8,
   parameter int DEF_CNT_LIM  = 16,
   parameter int DEF_TIME_LIM = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [31:0]      wr_data,
   output logic             eng_rst,
   output logic             irq_en,
   output logic             uncached,
   output logic [LIM_W-1:0] cnt_lim,
   output logic [LIM_W-1:0] time_lim
);

   logic set_wr, clr_wr, cfg_wr;

   assign set_wr = wr_en && (wr_sel == WSEL_SET);
   assign clr_wr = wr_en && (wr_sel == WSEL_CLR);
   assign cfg_wr = wr_en && (wr_sel == WSEL_CFG);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eng_rst  <= 1'b1;
         irq_en   <= 1'b0;
         uncached <= 1'b0;
      end else if (set_wr) begin
         eng_rst  <= eng_rst  | wr_data[CTL_RST_BIT];
         irq_en   <= irq_en   | wr_data[CTL_IEN_BIT];
         uncached <= uncached | wr_data[CTL_UNC_BIT];
      end else if (clr_wr) begin
         eng_rst  <= eng_rst  & ~wr_data[CTL_RST_BIT];
         irq_en   <= irq_en   & ~wr_data[CTL_IEN_BIT];
         uncached <= uncached & ~wr_data[CTL_UNC_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_lim  <= LIM_W'(DEF_CNT_LIM);
         time_lim <= LIM_W'(DEF_TIME_LIM);
      end else if (cfg_wr) begin
         cnt_lim  <= wr_data[CFG_CNT_LSB  +: LIM_W];
         time_lim <= wr_data[CFG_TIME_LSB +: LIM_W];
      end
   end

   logic unused_wr_bits;
   assign unused_wr_bits = ^wr_data;

endmodule

// File: rtl/rxc_batch_acc.sv
module rxc_batch_acc
   import rxc_pkg::*;
#(
   parameter int CNT_W         = 7,
   parameter int LIM_W         = 8,
   parameter int TMR_W         = 8,
   parameter bit TIME_LIMIT_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             eng_rst,
   input  logic             armed,
   input  logic             fire,
   input  logic             ack_take,
   input  logic             msg_in,
   input  logic             link_in,
   input  logic             tick_in,
   input  logic [LIM_W-1:0] cnt_lim,
   input  logic [LIM_W-1:0] time_lim,
   output logic [CNT_W-1:0] cnt_q,
   output logic             lnk_q,
   output logic             due
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam int CMP_W = (CNT_W > LIM_W) ? CNT_W : LIM_W;
   localparam int TCMP_W = (TMR_W > LIM_W) ? TMR_W : LIM_W;

   logic pending, cnt_hit, time_hit;

   assign pending = (cnt_q != '0);
   assign cnt_hit = CMP_W'(cnt_q) >= CMP_W'(cnt_lim);

   // batch message counter and link flag; fire-cycle events open the next batch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lnk_q <= 1'b0;
      end else if (eng_rst) begin
         cnt_q <= '0;
         lnk_q <= 1'b0;
      end else if (fire) begin
         cnt_q <= CNT_W'(msg_in);
         lnk_q <= link_in;
      end else begin
         if (msg_in && (cnt_q != CNT_MAX)) cnt_q <= cnt_q + 1'b1;
         lnk_q <= lnk_q | link_in;
      end
   end

   generate
      if (TIME_LIMIT_EN) begin : g_timer
         logic [TMR_W-1:0] tmr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               tmr_q <= '0;
            end else if (eng_rst || fire || ack_take) begin
               tmr_q <= '0;
            end else if (armed && pending && tick_in && (tmr_q != {TMR_W{1'b1}})) begin
               tmr_q <= tmr_q + 1'b1;
            end
         end
         assign time_hit = TCMP_W'(tmr_q) >= TCMP_W'(time_lim);
      end else begin : g_no_timer
         logic unused_timer_in;
         assign unused_timer_in = tick_in ^ armed ^ ack_take ^ (^time_lim);
         assign time_hit = 1'b0;
      end
   endgenerate

   assign due = lnk_q || (pending && (cnt_hit || time_hit));

endmodule

// File: rtl/rxc_handshake.sv
module rxc_handshake
   import rxc_pkg::*;
#(
   parameter int CNT_W = 7,
   parameter int TAG_W = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                eng_rst,
   input  logic                irq_en,
   input  logic                due,
   input  logic                ack_wr,
   input  logic [TAG_W-1:0]    ack_tag,
   input  logic [CNT_W-1:0]    cnt_q,
   input  logic                lnk_q,
   output logic                armed,
   output logic                fire,
   output logic                ack_take,
   output logic                irq,
   output logic [TAG_W-1:0]    tag_q,
   output logic [STATUS_W-1:0] status
);

   eng_state_e          state_q;
   logic [STATUS_W-1:0] status_d;

   assign armed    = (state_q == ENG_ARMED);
   assign fire     = armed && irq_en && due && !eng_rst;
   assign ack_take = ack_wr && !armed && !eng_rst;
   assign irq      = (state_q == ENG_FIRED) && irq_en;

   always_comb begin
      status_d = '0;
      status_d[ST_TAG_LSB +: TAG_W] = tag_q;
      status_d[ST_CNT_LSB +: CNT_W] = cnt_q;
      status_d[ST_LNK_BIT]          = lnk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         tag_q   <= '0;
         status  <= '0;
      end else if (eng_rst) begin
         state_q <= ENG_IDLE;
         status  <= '0;
      end else if (fire) begin
         state_q <= ENG_FIRED;
         status  <= status_d;
      end else if (ack_take) begin
         state_q <= ENG_ARMED;
         tag_q   <= ack_tag;
      end
   end

endmodule

// File: rtl/rx_irq_coalescer.sv
module rx_irq_coalescer
   import rxc_pkg::*;
#(
   parameter int CNT_W         = 7,
   parameter int TAG_W         = 4,
   parameter int LIM_W         = 8,
   parameter int TMR_W         = 8,
   parameter int DEF_CNT_LIM   = 16,
   parameter int DEF_TIME_LIM  = 10,
   parameter bit TIME_LIMIT_EN = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        msg_evt,
   input  logic        link_evt,
   input  logic        tick,
   input  logic        wr_en,
   input  logic [1:0]  wr_sel,
   input  logic [31:0] wr_data,
   output logic        irq,
   output logic [31:0] status,
   output logic        mem_uncached
);

   generate
      if (TAG_W < 1 || TAG_W > ST_CNT_LSB) begin : g_bad_tag
         $error("TAG_W must fit below the count field");
      end
      if (CNT_W < 1 || ST_CNT_LSB + CNT_W > ST_LNK_BIT) begin : g_bad_cnt
         $error("CNT_W must fit below the link flag");
      end
      if (LIM_W < 1 || LIM_W > CFG_TIME_LSB) begin : g_bad_lim
         $error("LIM_W must fit in one configuration byte");
      end
      if (TMR_W < LIM_W) begin : g_bad_tmr
         $error("TMR_W must cover the time limit range");
      end
      if (DEF_CNT_LIM >= (1 << LIM_W) || DEF_TIME_LIM >= (1 << LIM_W)) begin : g_bad_def
         $error("default limits exceed LIM_W");
      end
   endgenerate

   logic             eng_rst, irq_en;
   logic [LIM_W-1:0] cnt_lim, time_lim;
   logic [CNT_W-1:0] cnt_q;
   logic             lnk_q, due;
   logic             armed, fire, ack_take, ack_wr;
   logic [TAG_W-1:0] tag_q;

   assign ack_wr = wr_en && (wr_sel == WSEL_ACK);

   rxc_ctrl_regs #(
      .LIM_W(LIM_W), .DEF_CNT_LIM(DEF_CNT_LIM), .DEF_TIME_LIM(DEF_TIME_LIM)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .eng_rst(eng_rst), .irq_en(irq_en), .uncached(mem_uncached),
      .cnt_lim(cnt_lim), .time_lim(time_lim)
   );

   rxc_batch_acc #(
      .CNT_W(CNT_W), .LIM_W(LIM_W), .TMR_W(TMR_W), .TIME_LIMIT_EN(TIME_LIMIT_EN)
   ) u_acc (
      .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst), .armed(armed), .fire(fire),
      .ack_take(ack_take), .msg_in(msg_evt), .link_in(link_evt), .tick_in(tick),
      .cnt_lim(cnt_lim), .time_lim(time_lim), .cnt_q(cnt_q), .lnk_q(lnk_q), .due(due)
   );

   rxc_handshake #(
      .CNT_W(CNT_W), .TAG_W(TAG_W)
   ) u_hs (
      .clk(clk), .rst_n(rst_n), .eng_rst(eng_rst), .irq_en(irq_en), .due(due),
      .ack_wr(ack_wr), .ack_tag(wr_data[TAG_W-1:0]), .cnt_q(cnt_q), .lnk_q(lnk_q),
      .armed(armed), .fire(fire), .ack_take(ack_take), .irq(irq), .tag_q(tag_q),
      .status(status)
   );

endmodule

// File: rtl/rxc_checker.sv
module rxc_checker #(
   parameter int CNT_W = 7,
   parameter int TAG_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irq,
   input logic [31:0]      status,
   input logic             eng_rst,
   input logic             ack_take,
   input logic [TAG_W-1:0] tag_q
);

   // R3: one edge of engine reset leaves no interrupt and an empty status
   p_rst_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
      eng_rst |=> (!irq && status == 32'd0));

   // R7: an accepted acknowledge drops the interrupt in the next cycle
   p_ack_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ack_take |=> !irq);

   // R4: a fired batch keeps its status until the host acknowledges
   p_status_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_take && !eng_rst) |=> $stable(status));

   // R6: a batch without the link flag always carries messages
   p_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irq) && !status[16]) |-> (status[4 +: CNT_W] != '0));

   // R7: the reported tag is the one taken from the last acknowledge
   p_tag_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> (status[TAG_W-1:0] == tag_q));

endmodule

bind rx_irq_coalescer rxc_checker #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .irq(irq), .status(status),
   .eng_rst(eng_rst), .ack_take(ack_take), .tag_q(tag_q)
);

// File: tb/rx_irq_coalescer_tb_top.sv
module rx_irq_coalescer_tb_top;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        msg_evt = 1'b0, link_evt = 1'b0, tick = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [31:0] wr_data = 32'd0;
   logic        irq, mem_uncached;
   logic [31:0] status;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   rx_irq_coalescer dut_i (
      .clk(clk), .rst_n(rst_n), .msg_evt(msg_evt), .link_evt(link_evt), .tick(tick),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq(irq), .status(status), .mem_uncached(mem_uncached)
   );

   // reference model state (0 idle, 1 armed, 2 fired)
   bit          m_rst, m_ien, m_unc, m_lnk;
   int          m_cl, m_tl, m_st, m_cnt, m_tmr;
   logic [3:0]  m_tag;
   logic [31:0] m_stat;

   function automatic logic [31:0] pack(bit lnk, int cnt, logic [3:0] tag);
      return (lnk ? 32'h0001_0000 : 32'd0) | (32'(cnt) << 4) | 32'(tag);
   endfunction

   task automatic model_reset();
      m_rst = 1; m_ien = 0; m_unc = 0; m_lnk = 0;
      m_cl = 16; m_tl = 10; m_st = 0; m_cnt = 0; m_tmr = 0;
      m_tag = 4'd0; m_stat = 32'd0;
   endtask

   task automatic model_step(bit m, bit l, bit t, bit we, logic [1:0] sel, logic [31:0] d);
      bit fire, acc;
      if (m_rst) begin
         m_cnt = 0; m_lnk = 0; m_tmr = 0; m_st = 0; m_stat = 32'd0;
      end else begin
         fire = (m_st == 1) && m_ien &&
                (m_lnk || (m_cnt > 0 && (m_cnt >= m_cl || m_tmr >= m_tl)));
         acc  = we && sel == 2'd3 && m_st != 1;
         if (fire) begin
            m_stat = pack(m_lnk, m_cnt, m_tag);
            m_st = 2; m_cnt = m ? 1 : 0; m_lnk = l; m_tmr = 0;
         end else begin
            if (acc) m_tmr = 0;
            else if (m_st == 1 && m_cnt > 0 && t && m_tmr < 255) m_tmr++;
            if (m && m_cnt < 127) m_cnt++;
            m_lnk = m_lnk | l;
            if (acc) begin m_st = 1; m_tag = d[3:0]; end
         end
      end
      if (we && sel == 2'd0) begin
         m_unc |= d[16]; m_rst |= d[17]; m_ien |= d[18];
      end else if (we && sel == 2'd1) begin
         m_unc &= ~d[16]; m_rst &= ~d[17]; m_ien &= ~d[18];
      end else if (we && sel == 2'd2) begin
         m_cl = int'(d[7:0]); m_tl = int'(d[15:8]);
      end
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(bit m, bit l, bit t, bit we, logic [1:0] sel, logic [31:0] d);
      @(negedge clk);
      msg_evt = m; link_evt = l; tick = t; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk);
      model_step(m, l, t, we, sel, d);
      #1;
      check("model irq (R4,R5,R6,R7,R8)", 32'(irq), 32'((m_st == 2) && m_ien));
      check("model status (R4,R9)", status, m_stat);
      check("model uncached (R2)", 32'(mem_uncached), 32'(m_unc));
   endtask

   task automatic idle(int n);  for (int i = 0; i < n; i++) step(0, 0, 0, 0, 2'd0, 0); endtask
   task automatic msgs(int n);  for (int i = 0; i < n; i++) step(1, 0, 0, 0, 2'd0, 0); endtask
   task automatic ticks(int n); for (int i = 0; i < n; i++) step(0, 0, 1, 0, 2'd0, 0); endtask
   task automatic wr(logic [1:0] sel, logic [31:0] d); step(0, 0, 0, 1, sel, d); endtask

   localparam logic [31:0] B_UNC = 32'h0001_0000;
   localparam logic [31:0] B_RST = 32'h0002_0000;
   localparam logic [31:0] B_IEN = 32'h0004_0000;

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      int unsigned seed_v;
      seed_v = $urandom(32'd20240611);
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 irq at reset", 32'(irq), 0);
      check("R1 status at reset", status, 0);
      check("R1 uncached at reset", 32'(mem_uncached), 0);

      // R1 default limits, R4 count fire
      wr(2'd1, B_RST);
      wr(2'd3, 32'd1);
      wr(2'd0, B_IEN);
      msgs(16);
      check("R4 no fire before limit seen", 32'(irq), 0);
      idle(1);
      check("R4 fire at default count R1", 32'(irq), 1);
      check("R4 status word", status, 32'h0000_0101);

      // R9 next batch, R7 ack, R5 timer
      msgs(3);
      wr(2'd3, 32'd2);
      check("R7 irq drops after ack", 32'(irq), 0);
      ticks(10);
      check("R5 no fire at limit edge", 32'(irq), 0);
      idle(1);
      check("R5 time fire status, R9 carried batch", status, 32'h0000_0032);
      check("R5 time fire irq", 32'(irq), 1);

      // R6 link alone
      wr(2'd3, 32'd3);
      step(0, 1, 0, 0, 2'd0, 0);
      idle(1);
      check("R6 link status", status, 32'h0001_0003);

      // R8 enable gating
      wr(2'd3, 32'd4);
      wr(2'd1, B_IEN);
      msgs(20);
      check("R8 no irq while disabled", 32'(irq), 0);
      wr(2'd0, B_IEN);
      idle(1);
      check("R8 fire after enable", status, 32'h0000_0144);

      // R7 ack while armed ignored
      wr(2'd3, 32'd5);
      wr(2'd3, 32'd7);
      msgs(16);
      idle(1);
      check("R7 second ack ignored", status, 32'h0000_0105);

      // R3 engine reset
      wr(2'd3, 32'd6);
      msgs(5);
      wr(2'd0, B_RST);
      idle(1);
      check("R3 status cleared in reset", status, 0);
      msgs(5);
      wr(2'd3, 32'd8);
      wr(2'd1, B_RST);
      msgs(16);
      idle(1);
      check("R3 ack in reset ignored", 32'(irq), 0);
      wr(2'd3, 32'd9);
      idle(1);
      check("R3 discarded events, fresh batch", status, 32'h0000_0109);

      // R9 saturation, R10 config fields
      wr(2'd3, 32'd10);
      wr(2'd2, 32'h0000_FFC8);
      msgs(130);
      check("R10 high limits hold off", 32'(irq), 0);
      wr(2'd2, 32'h0000_00C8);
      idle(1);
      check("R9 saturated count", status, 32'h0000_07FA);

      // R2 uncached flag
      wr(2'd0, B_UNC);
      check("R2 uncached set", 32'(mem_uncached), 1);
      wr(2'd1, B_UNC);
      check("R2 uncached clear", 32'(mem_uncached), 0);

      // random phase
      wr(2'd2, 32'h0000_0305);
      for (int i = 0; i < 3000; i++) begin
         int r;
         bit m, l, t;
         r = int'($urandom % 100);
         m = ($urandom % 100) < 30;
         l = ($urandom % 100) < 3;
         t = ($urandom % 100) < 25;
         if (r < 2)
            step(m, l, t, 1, 2'd2, {16'd0, 8'($urandom % 7), 8'($urandom % 21)});
         else if (r < 4)
            step(m, l, t, 1, m_ien ? 2'd1 : 2'd0, B_IEN);
         else if (r < 5)
            step(m, l, t, 1, m_rst ? 2'd1 : 2'd0, B_RST);
         else if (r < 25 && (irq || m_st == 0))
            step(m, l, t, 1, 2'd3, 32'(m_stat[3:0] + 4'd1));
         else if (r < 27)
            step(m, l, t, 1, 2'd3, 32'($urandom % 16));
         else
            step(m, l, t, 0, 2'd0, 0);
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule